// File: doc/BRIEF.md
# Reloadable 16-bit Timer and Baud Tick Generator

This block is a 16-bit counter with its own 16-bit reload register. A small byte-wide register port configures it and reads it back. It advances on either an internal prescaled tick or on falling edges of an external count pin. It runs in one of four modes:

- **Auto-reload up counting.** An external trigger pin can force a reload.
- **Capture.** A trigger edge copies the live count into the reload register.
- **Up/down counting.** The level of the trigger pin selects the direction.
- **Baud generation.** Each rollover produces a one-cycle tick for a transmitter, a receiver, or both.

An overflow flag and an external-event flag report events. Software clears each flag by writing 0 to it. Both baud ticks and every reload take their value from the same reload register, so the tick rate always follows that register.

Top module: `rld_timer16`

## Requirements
- R1: After a synchronous reset the control byte, the counter, the reload register and both flags are zero and both ticks are low. The readback addresses are: 0 control, 1 counter low byte, 2 counter high byte, 3 reload low byte, 4 reload high byte, 5 flags (bit 0 overflow, bit 1 external). Control bits are: 0 run, 1 external count source, 2 capture select, 3 trigger enable, 4 up/down enable, 5 transmit baud, 6 receive baud. Control bit 7 always reads 0.
- R2: With run set and the internal source selected outside baud mode, the counter advances once every 12 clocks. The first step comes 12 clocks after run is written. With run clear the counter holds.
- R3: When an up count passes 0xFFFF in reload or up/down mode, the counter loads the reload value and the overflow flag sets.
- R4: With the external source selected, the counter advances once per falling edge of the count pin, taking effect on the third clock edge after the pin is sampled low. A pin held at one level does not count.
- R5: With up/down enable set (and capture select clear), trigger pin high counts up and low counts down. A down step taken while the counter equals the reload value loads 0xFFFF and sets the overflow flag. Trigger edges cause no action in this mode.
- R6: In reload mode with trigger enable set, a falling trigger edge loads the reload value into the counter and sets the external flag. With trigger enable clear, the edge does nothing.
- R7: In capture mode a falling trigger edge (trigger enable set) copies the counter into the reload register and sets the external flag. An up overflow wraps the counter to 0 and sets the overflow flag.
- R8: When either baud bit is set, capture select and up/down enable are ignored. The counter then counts up, reloads on overflow and uses a divide-by-2 internal tick, so the tick period is (65536 - reload) x 2 clocks. The overflow flag is never set in this mode.
- R9: The transmit tick and the receive tick are separate one-clock pulses, each produced on a baud-mode rollover only while its own control bit is set.
- R10: Writing 0 to a flag bit at address 5 clears that flag and writing 1 leaves it unchanged. A hardware set in the same clock wins over the clear.
- R11: In baud mode a falling trigger edge with trigger enable set sets only the external flag and leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register readback, combinational |
| cnt_pin | input | 1 | External count pin, falling edges counted |
| trig_pin | input | 1 | Trigger pin: falling edge events, level sets direction |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External event flag |
| tx_tick | output | 1 | Transmit baud tick pulse |
| rx_tick | output | 1 | Receive baud tick pulse |

## Verification
A wrong reload or capture value shows up on the readback of the counter or reload bytes at the next rollover or trigger edge, which is no more than a few hundred clocks away in the directed cases. A prescaler or mode decode error changes the spacing between consecutive baud ticks, so the measured interval differs from (65536 - reload) x 2 within one period. A flag priority error is caught by a clear written in the very clock of a rollover. A synchronizer latency error shifts the count seen three edges after a pin falls.

// File: rtl/rld_timer16_pkg.sv
package rld_timer16_pkg;

    localparam int DATA_W = 8;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd5;

    typedef struct packed {
        logic rsv;
        logic rx_baud;
        logic tx_baud;
        logic updown;
        logic ext_en;
        logic cap_sel;
        logic ext_src;
        logic run;
    } ctrl_t;

    typedef enum logic [1:0] {
        M_RELOAD  = 2'd0,
        M_CAPTURE = 2'd1,
        M_UPDOWN  = 2'd2,
        M_BAUD    = 2'd3
    } mode_e;

    // baud overrides capture, capture overrides up/down
    function automatic mode_e pick_mode(ctrl_t c);
        if (c.tx_baud || c.rx_baud) return M_BAUD;
        if (c.cap_sel)              return M_CAPTURE;
        if (c.updown)               return M_UPDOWN;
        return M_RELOAD;
    endfunction

    function automatic logic [CNT_W-1:0] put_byte(logic [CNT_W-1:0] v, logic hi,
                                                   logic [DATA_W-1:0] b);
        logic [CNT_W-1:0] r;
        r = v;
        if (hi) r[CNT_W-1:DATA_W] = b;
        else    r[DATA_W-1:0]     = b;
        return r;
    endfunction

endpackage

// File: rtl/rld_timer16_edge.sv
module rld_timer16_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            last  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            last  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign fall  = last & ~chain[STAGES-1];

    AST_FALL_ONCE: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall); // R4

endmodule

// File: rtl/rld_timer16_presc.sv
module rld_timer16_presc #(
    parameter int NORM_DIV = 12,
    parameter int BAUD_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic fast,
    output logic tick
);
    localparam int W = (NORM_DIV > 2) ? $clog2(NORM_DIV) : 1;
    localparam logic [W-1:0] LIM_N = W'(NORM_DIV - 1);
    localparam logic [W-1:0] LIM_B = W'(BAUD_DIV - 1);

    logic [W-1:0] pre_q;
    logic [W-1:0] lim;

    assign lim  = fast ? LIM_B : LIM_N;
    assign tick = en && (pre_q >= lim);

    always_ff @(posedge clk) begin
        if (rst || !en)  pre_q <= '0;
        else if (tick)   pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R2

endmodule

// File: rtl/rld_timer16_core.sv
module rld_timer16_core
    import rld_timer16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  mode_e             mode,
    input  logic              step,
    input  logic              dir_up,
    input  logic              trig_evt,
    input  logic              wr_cnt_lo,
    input  logic              wr_cnt_hi,
    input  logic              wr_rld_lo,
    input  logic              wr_rld_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx_en,
    input  logic              rx_en,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  rld_q,
    output logic              ovf_set,
    output logic              ext_set,
    output logic              tx_tick,
    output logic              rx_tick
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic             going_up, roll_up, roll_dn, baud_roll, trig_reload;
    logic [CNT_W-1:0] cnt_nx, rld_nx;

    assign going_up    = (mode != M_UPDOWN) || dir_up;
    assign roll_up     = step && going_up && (cnt_q == TOP);
    assign roll_dn     = step && !going_up && (cnt_q == rld_q);
    assign baud_roll   = roll_up && (mode == M_BAUD);
    assign trig_reload = trig_evt && (mode == M_RELOAD);
    assign ovf_set     = (roll_up || roll_dn) && (mode != M_BAUD);
    assign ext_set     = trig_evt && (mode != M_UPDOWN);

    always_comb begin
        cnt_nx = cnt_q;
        if (step) begin
            if (going_up)
                cnt_nx = roll_up ? ((mode == M_CAPTURE) ? '0 : rld_q) : cnt_q + 1'b1;
            else
                cnt_nx = roll_dn ? TOP : cnt_q - 1'b1;
        end
        if (trig_reload) cnt_nx = rld_q;
        if (wr_cnt_lo)   cnt_nx = put_byte(cnt_nx, 1'b0, wdata);
        if (wr_cnt_hi)   cnt_nx = put_byte(cnt_nx, 1'b1, wdata);
    end

    always_comb begin
        rld_nx = rld_q;
        if (wr_rld_lo) rld_nx = put_byte(rld_nx, 1'b0, wdata);
        if (wr_rld_hi) rld_nx = put_byte(rld_nx, 1'b1, wdata);
        if (trig_evt && (mode == M_CAPTURE)) rld_nx = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            rld_q   <= '0;
            tx_tick <= 1'b0;
            rx_tick <= 1'b0;
        end else begin
            cnt_q   <= cnt_nx;
            rld_q   <= rld_nx;
            tx_tick <= baud_roll && tx_en;
            rx_tick <= baud_roll && rx_en;
        end
    end

    AST_UP_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (roll_up && mode != M_CAPTURE && !wr_cnt_lo && !wr_cnt_hi)
        |=> cnt_q == $past(rld_q)); // R3

    AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
        (roll_dn && !wr_cnt_lo && !wr_cnt_hi) |=> cnt_q == TOP); // R5

    AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (rst)
        (trig_evt && mode == M_CAPTURE) |=> rld_q == $past(cnt_q)); // R7

    AST_TX_PULSE: assert property (@(posedge clk) disable iff (rst)
        tx_tick |=> !tx_tick); // R9

    AST_RX_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_tick |=> !rx_tick); // R9

endmodule

// File: rtl/rld_timer16.sv
module rld_timer16
    import rld_timer16_pkg::*;
#(
    parameter int NORM_DIV    = 12,
    parameter int BAUD_DIV    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    output logic              ovf_flag,
    output logic              ext_flag,
    output logic              tx_tick,
    output logic              rx_tick
);
    ctrl_t            ctrl_q;
    mode_e            mode;
    logic             ovf_q, ext_q;
    logic             cnt_fall, cnt_lvl, trig_fall, trig_lvl;
    logic             pre_tick, step, trig_evt;
    logic             ovf_set, ext_set, flag_wr;
    logic [CNT_W-1:0] cnt_v, rld_v;

    assign mode    = pick_mode(ctrl_q);
    assign flag_wr = wr_en && (wr_addr == A_FLAGS);

    rld_timer16_edge #(.STAGES(SYNC_STAGES)) u_cnt_edge (
        .clk(clk), .rst(rst), .pin(cnt_pin), .level(cnt_lvl), .fall(cnt_fall));

    rld_timer16_edge #(.STAGES(SYNC_STAGES)) u_trig_edge (
        .clk(clk), .rst(rst), .pin(trig_pin), .level(trig_lvl), .fall(trig_fall));

    rld_timer16_presc #(.NORM_DIV(NORM_DIV), .BAUD_DIV(BAUD_DIV)) u_presc (
        .clk(clk), .rst(rst),
        .en(ctrl_q.run && !ctrl_q.ext_src),
        .fast(mode == M_BAUD),
        .tick(pre_tick));

    assign step     = ctrl_q.run && (ctrl_q.ext_src ? cnt_fall : pre_tick);
    assign trig_evt = trig_fall && ctrl_q.ext_en;

    rld_timer16_core u_core (
        .clk(clk), .rst(rst), .mode(mode), .step(step), .dir_up(trig_lvl),
        .trig_evt(trig_evt),
        .wr_cnt_lo(wr_en && wr_addr == A_CNT_LO),
        .wr_cnt_hi(wr_en && wr_addr == A_CNT_HI),
        .wr_rld_lo(wr_en && wr_addr == A_RLD_LO),
        .wr_rld_hi(wr_en && wr_addr == A_RLD_HI),
        .wdata(wr_data), .tx_en(ctrl_q.tx_baud), .rx_en(ctrl_q.rx_baud),
        .cnt_q(cnt_v), .rld_q(rld_v), .ovf_set(ovf_set), .ext_set(ext_set),
        .tx_tick(tx_tick), .rx_tick(rx_tick));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ovf_q  <= 1'b0;
            ext_q  <= 1'b0;
        end else begin
            if (wr_en && wr_addr == A_CTRL) begin
                ctrl_q     <= ctrl_t'(wr_data);
                ctrl_q.rsv <= 1'b0;
            end
            ovf_q <= ovf_set || (ovf_q && !(flag_wr && !wr_data[0]));
            ext_q <= ext_set || (ext_q && !(flag_wr && !wr_data[1]));
        end
    end

    always_comb begin
        case (rd_addr)
            A_CTRL:   rd_data = ctrl_q;
            A_CNT_LO: rd_data = cnt_v[DATA_W-1:0];
            A_CNT_HI: rd_data = cnt_v[CNT_W-1:DATA_W];
            A_RLD_LO: rd_data = rld_v[DATA_W-1:0];
            A_RLD_HI: rd_data = rld_v[CNT_W-1:DATA_W];
            A_FLAGS:  rd_data = {{(DATA_W-2){1'b0}}, ext_q, ovf_q};
            default:  rd_data = '0;
        endcase
    end

    assign ovf_flag = ovf_q;
    assign ext_flag = ext_q;

    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        ovf_set |=> ovf_q); // R10

    AST_EXT_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        ext_set |=> ext_q); // R10

    AST_BAUD_NO_OVF: assert property (@(posedge clk) disable iff (rst)
        (mode == M_BAUD && !ovf_q) |=> !ovf_q); // R8

    AST_BAUD_NO_RELOAD_ON_TRIG: assert property (@(posedge clk) disable iff (rst)
        (mode == M_BAUD && trig_evt && !step && !wr_en) |=> $stable(cnt_v)); // R11

endmodule

// File: tb/rld_timer16_test.sv
module rld_timer16_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       cnt_pin = 1'b1;
    logic       trig_pin = 1'b1;
    logic       ovf_flag, ext_flag, tx_tick, rx_tick;

    int ntests = 0;
    int nfail  = 0;
    bit done   = 0;

    localparam logic [7:0] C_RUN = 8'h01, C_EXT = 8'h02, C_CAP = 8'h04, C_TEN = 8'h08,
                           C_UD  = 8'h10, C_TX  = 8'h20, C_RX  = 8'h40;

    rld_timer16 uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
        .ovf_flag(ovf_flag), .ext_flag(ext_flag), .tx_tick(tx_tick), .rx_tick(rx_tick));

    always #(CLK_P/2) clk = ~clk;

    function automatic int exp_timer(int start, int k);
        return (start + k / 12) & 16'hFFFF;
    endfunction

    function automatic int exp_baud_period(int r);
        return (65536 - r) * 2;
    endfunction

    task automatic check(string tag, int act, int exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic rd16(logic [2:0] lo, output int v);
        logic [7:0] l, h;
        rd(lo, l);
        rd(lo + 3'd1, h);
        v = {h, l};
    endtask

    task automatic set_cnt(int v);
        wr(3'd1, v[7:0]);
        wr(3'd2, v[15:8]);
    endtask

    task automatic set_rld(int v);
        wr(3'd3, v[7:0]);
        wr(3'd4, v[15:8]);
    endtask

    task automatic pulse_cnt();
        cnt_pin = 1'b0;
        repeat (3) @(negedge clk);
        cnt_pin = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_trig();
        trig_pin = 1'b0;
        repeat (3) @(negedge clk);
        trig_pin = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // counts negedges until the chosen tick is seen; reports whether the other tick appeared
    task automatic measure(bit use_rx, output int n, output bit other_seen);
        n = 0;
        other_seen = 0;
        do begin
            @(negedge clk);
            n++;
            if (use_rx ? tx_tick : rx_tick) other_seen = 1;
        end while (!(use_rx ? rx_tick : tx_tick) && n < 3000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        int v, r, k, s, n;
        bit oth;
        void'($urandom(32'd51966));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd(3'd0, b); check("R1 ctrl reset", b, 0);
        rd16(3'd1, v); check("R1 cnt reset", v, 0);
        rd16(3'd3, v); check("R1 rld reset", v, 0);
        rd(3'd5, b); check("R1 flags reset", b, 0);
        check("R1 ticks reset", {tx_tick, rx_tick}, 0);
        wr(3'd0, 8'hFF); rd(3'd0, b); check("R1 ctrl bit7 reads 0", b, 8'h7F);
        wr(3'd0, 8'h00); wr(3'd5, 8'h00);

        // R2: internal timer rate, random starts and lengths
        for (int i = 0; i < 5; i++) begin
            wr(3'd0, 8'h00);
            s = $urandom % 16'hF000;
            k = 12 * ($urandom % 8) + ($urandom % 12);
            set_cnt(s);
            wr(3'd0, C_RUN);
            repeat (k) @(negedge clk);
            rd16(3'd1, v); check("R2 timer count", v, exp_timer(s, k));
        end
        wr(3'd0, 8'h00);
        rd16(3'd1, s);
        repeat (40) @(negedge clk);
        rd16(3'd1, v); check("R2 hold when stopped", v, s);

        // R3: up overflow reloads
        for (int i = 0; i < 3; i++) begin
            wr(3'd0, 8'h00); wr(3'd5, 8'h00);
            r = $urandom & 16'hFFFF;
            set_rld(r); set_cnt(16'hFFFE);
            wr(3'd0, C_RUN);
            repeat (24) @(negedge clk);
            rd16(3'd1, v); check("R3 reload after overflow", v, r);
            check("R3 overflow flag", ovf_flag, 1);
        end

        // R10: clear by writing 0, writing 1 keeps
        wr(3'd5, 8'h01); check("R10 write 1 keeps flag", ovf_flag, 1);
        wr(3'd5, 8'h00); check("R10 write 0 clears flag", ovf_flag, 0);

        // R4: external count edges
        wr(3'd0, 8'h00); set_cnt(16'h0100);
        wr(3'd0, C_RUN | C_EXT);
        k = 3 + $urandom % 5;
        for (int i = 0; i < k; i++) pulse_cnt();
        rd16(3'd1, v); check("R4 external count", v, 16'h0100 + k);
        cnt_pin = 1'b0;
        repeat (20) @(negedge clk);
        rd16(3'd1, v); check("R4 steady pin counts once", v, 16'h0101 + k);
        cnt_pin = 1'b1;
        repeat (4) @(negedge clk);
        // R4: latency, step lands on third edge after the pin is sampled low
        cnt_pin = 1'b0;
        @(negedge clk); @(negedge clk);
        rd16(3'd1, v); check("R4 no count after two edges", v, 16'h0101 + k);
        @(negedge clk);
        rd16(3'd1, v); check("R4 count on third edge", v, 16'h0102 + k);
        cnt_pin = 1'b1;
        repeat (4) @(negedge clk);

        // R10: hardware set in same clock as a clear
        wr(3'd0, 8'h00); wr(3'd5, 8'h00);
        set_rld(16'h4321); set_cnt(16'hFFFF);
        wr(3'd0, C_RUN | C_EXT);
        cnt_pin = 1'b0;
        @(negedge clk); @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd5; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 set wins over clear", ovf_flag, 1);
        rd16(3'd1, v); check("R3 reload on external overflow", v, 16'h4321);
        cnt_pin = 1'b1;
        repeat (4) @(negedge clk);

        // R5: up/down counting
        wr(3'd0, 8'h00); wr(3'd5, 8'h00);
        trig_pin = 1'b0;
        repeat (4) @(negedge clk);
        r = 16'h0200 + ($urandom % 16'h8000);
        set_rld(r); set_cnt(r + 1);
        wr(3'd0, C_RUN | C_EXT | C_UD | C_TEN);
        pulse_cnt();
        rd16(3'd1, v); check("R5 count down", v, r);
        check("R5 no flag before floor", ovf_flag, 0);
        pulse_cnt();
        rd16(3'd1, v); check("R5 underflow to FFFF", v, 16'hFFFF);
        check("R5 underflow flag", ovf_flag, 1);
        wr(3'd5, 8'h00);
        trig_pin = 1'b1;
        repeat (4) @(negedge clk);
        pulse_cnt();
        rd16(3'd1, v); check("R5 count up reloads", v, r);
        pulse_trig();
        rd16(3'd1, v); check("R5 trigger edge ignored", v, r);
        check("R5 no ext flag", ext_flag, 0);

        // R6: trigger reload
        wr(3'd0, C_TEN); wr(3'd5, 8'h00);
        r = $urandom & 16'hFFFF;
        set_rld(r); set_cnt(16'h1234);
        pulse_trig();
        rd16(3'd1, v); check("R6 trigger reload", v, r);
        check("R6 ext flag", ext_flag, 1);
        wr(3'd5, 8'h00); wr(3'd0, 8'h00); set_cnt(16'h1234);
        pulse_trig();
        rd16(3'd1, v); check("R6 disabled trigger keeps count", v, 16'h1234);
        check("R6 disabled trigger no flag", ext_flag, 0);

        // R7: capture and wrap
        s = $urandom & 16'hFFFF;
        wr(3'd0, C_CAP | C_TEN); set_rld(16'h0F0F); set_cnt(s);
        pulse_trig();
        rd16(3'd3, v); check("R7 capture into reload", v, s);
        rd16(3'd1, v); check("R7 counter kept on capture", v, s);
        check("R7 ext flag", ext_flag, 1);
        wr(3'd5, 8'h00); set_cnt(16'hFFFF);
        wr(3'd0, C_CAP | C_RUN | C_EXT);
        pulse_cnt();
        rd16(3'd1, v); check("R7 overflow wraps to 0", v, 0);
        check("R7 overflow flag", ovf_flag, 1);

        // R8 / R9: baud periods, random reload values
        for (int i = 0; i < 4; i++) begin
            bit use_rx;
            use_rx = (i == 3);
            wr(3'd0, 8'h00); wr(3'd5, 8'h00);
            r = 16'hFF00 | ($urandom % 8'hF0);
            set_rld(r); set_cnt(r);
            wr(3'd0, (use_rx ? C_RX : C_TX) | C_CAP | C_UD | C_RUN);
            measure(use_rx, n, oth);
            measure(use_rx, n, oth);
            check(use_rx ? "R8 rx baud period" : "R8 tx baud period", n, exp_baud_period(r));
            check("R9 other tick silent", oth, 0);
            check("R8 no overflow flag in baud", ovf_flag, 0);
        end
        // R9: both ticks together
        wr(3'd0, 8'h00);
        set_rld(16'hFFF8); set_cnt(16'hFFF8);
        wr(3'd0, C_TX | C_RX | C_RUN);
        measure(1'b0, n, oth);
        check("R9 rx ticks with tx", rx_tick, 1);

        // R11: trigger in baud mode only flags
        wr(3'd0, C_TX | C_TEN); wr(3'd5, 8'h00);
        set_rld(16'hABCD); set_cnt(16'h5555);
        pulse_trig();
        rd16(3'd1, v); check("R11 baud trigger keeps count", v, 16'h5555);
        check("R11 baud trigger sets ext", ext_flag, 1);
        check("R11 baud trigger no ovf", ovf_flag, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule